// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Cluster

This block holds a small set of processor-side cache controllers that share one bus and one backing memory. Each controller keeps a direct-mapped cache of one-word lines and serves load and store requests from its own processor port. Loads and stores that the local copy can satisfy finish without touching the bus. Every other request waits for a bus grant. Exactly one controller owns the bus in a cycle and completes its whole transaction in that cycle. Every other controller compares the address on the bus with its own lines and acts on a match.

Each line is Invalid, Shared or Modified. A controller must own a line before a store changes it, and any other copy is dropped in the same bus transaction. A store that finds its line Shared sends an upgrade with no data fetch. A store that misses sends a read-for-ownership. A controller that holds a line Modified and sees another master read that line supplies its data on the bus, updates memory, and keeps a Shared copy. When a miss evicts a Modified line, the controller writes the old word back to memory in the same transaction.

A processor raises its request with the operation, address and store data, and holds them until its done pulse.

Top module: `snoop_cluster`

## Requirements
- R1: After reset every line of every controller is Invalid and no done pulse or bus transaction is present. The first load of address `a` therefore goes to the bus and returns the memory reset value `a XOR 0xA5`.
- R2: A load that finds its line Shared or Modified with a matching tag completes with the cached word and produces no bus transaction (bus_cmd 0).
- R3: A load miss issues exactly one READ transaction (bus_cmd 1) and leaves the line Shared. Whenever bus_valid is high, bus_cmd is never 0.
- R4: A store to a Shared line issues exactly one UPGRADE transaction (bus_cmd 3) and fetches no data. Afterwards no other controller holds a valid copy of a line that some controller holds Modified.
- R5: A store miss issues exactly one READ-EXCLUSIVE transaction (bus_cmd 2) and leaves the line Modified with the store data.
- R6: A store to a line already Modified completes with no bus transaction.
- R7: When another master reads a line held Modified, the holder supplies the current word in that transaction, memory is updated, and the holder drops to Shared. The holder's next store to that line therefore issues an UPGRADE.
- R8: After a line is invalidated by another master's store, a load of that address by the former holder misses and returns the latest stored value.
- R9: A miss whose index holds a different Modified line writes that line's word back to memory in the same transaction, so a later load of it by another controller returns the stored value.
- R10: At most one controller is granted per cycle. Simultaneous requests are served by distinct owners in successive transactions (round-robin).
- R11: Each request produces exactly one done pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | NCPU | Per-processor request, held until done |
| cpu_we | input | NCPU | 1 = store, 0 = load |
| cpu_addr | input | NCPU*ADDR_W | Per-processor word address, processor i at slice i |
| cpu_wdata | input | NCPU*DATA_W | Per-processor store data |
| cpu_done | output | NCPU | One-cycle completion pulse |
| cpu_rdata | output | NCPU*DATA_W | Load result, valid with done |
| bus_valid | output | 1 | A bus transaction occurs this cycle |
| bus_cmd | output | 2 | 0 none, 1 READ, 2 READ-EXCLUSIVE, 3 UPGRADE |
| bus_owner | output | OW | Index of the granted controller |
| bus_addr | output | ADDR_W | Address of the current transaction |

## Verification
The bench builds the cluster with two controllers, four lines, 8-bit addresses and 8-bit data. With only four lines, addresses that differ above bit 1 collide at the same index. This makes victim write-back easy to provoke. With two controllers, every Shared/Modified hand-over between owners is visible at the bus command port, and so is round-robin alternation under simultaneous misses.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_READX = 2'd2,
        BC_UPGR  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RESP = 1'b1
    } phase_e;

    localparam logic [7:0] MEM_SEED = 8'hA5;

    function automatic logic cmd_takes_ownership(bus_cmd_e c);
        return (c == BC_READX) || (c == BC_UPGR);
    endfunction

    function automatic logic cmd_needs_data(bus_cmd_e c);
        return (c == BC_READ) || (c == BC_READX);
    endfunction

endpackage

// File: rtl/snoop_arb.sv
module snoop_arb #(
    parameter int N = 2,
    localparam int OW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [OW-1:0] owner
);
    logic [OW-1:0] ptr;

    always_comb begin
        grant = '0;
        owner = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (req[c] && grant == '0) begin
                grant[c] = 1'b1;
                owner    = OW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (grant != '0) begin
            ptr <= OW'((int'(owner) + 1) % N);
        end
    end
endmodule

// File: rtl/snoop_mem.sv
module snoop_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              fl_en,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_data
);
    import snoop_pkg::*;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(i) ^ DATA_W'(MEM_SEED);
            end
        end else begin
            if (wb_en) mem[wb_addr] <= wb_data;
            if (fl_en) mem[fl_addr] <= fl_data;
        end
    end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic                   done,
    output logic [DATA_W-1:0]      rdata,
    output logic                   bus_req,
    input  logic                   grant,
    input  logic                   bus_valid,
    input  snoop_pkg::bus_cmd_e    bus_cmd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_rdata,
    output snoop_pkg::bus_cmd_e    my_cmd,
    output logic                   wb_en,
    output logic [ADDR_W-1:0]      wb_addr,
    output logic [DATA_W-1:0]      wb_data,
    output logic                   flush_en,
    output logic [DATA_W-1:0]      flush_data,
    output logic [LINES-1:0]       val_o,
    output logic [LINES-1:0]       mod_o,
    output logic [LINES*TAG_W-1:0] tag_o
);
    import snoop_pkg::*;

    line_st_e          st  [LINES];
    logic [TAG_W-1:0]  tg  [LINES];
    logic [DATA_W-1:0] dat [LINES];
    phase_e            phase;

    logic [IDX_W-1:0] idx, sidx;
    logic [TAG_W-1:0] tag, stag;
    logic hit, active, local_ok, local_go, shit;

    assign idx  = addr[IDX_W-1:0];
    assign tag  = addr[ADDR_W-1:IDX_W];
    assign sidx = bus_addr[IDX_W-1:0];
    assign stag = bus_addr[ADDR_W-1:IDX_W];

    assign hit      = (st[idx] != LN_INV) && (tg[idx] == tag);
    assign active   = req && (phase == PH_IDLE);
    assign local_ok = hit && (!we || st[idx] == LN_MOD);
    // a snoop touching the same index this cycle takes precedence
    assign shit     = bus_valid && !grant && (st[sidx] != LN_INV) && (tg[sidx] == stag);
    assign local_go = active && local_ok && !(shit && sidx == idx);
    assign bus_req  = active && !local_ok;

    always_comb begin
        if (!hit) my_cmd = we ? BC_READX : BC_READ;
        else      my_cmd = BC_UPGR;
    end

    assign wb_en      = !hit && (st[idx] == LN_MOD);
    assign wb_addr    = {tg[idx], idx};
    assign wb_data    = dat[idx];
    assign flush_en   = shit && (st[sidx] == LN_MOD) && cmd_needs_data(bus_cmd);
    assign flush_data = dat[sidx];

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_stat
            assign val_o[l] = (st[l] != LN_INV);
            assign mod_o[l] = (st[l] == LN_MOD);
            assign tag_o[l*TAG_W +: TAG_W] = tg[l];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LINES; l++) begin
                st[l]  <= LN_INV;
                tg[l]  <= '0;
                dat[l] <= '0;
            end
            phase <= PH_IDLE;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (phase == PH_RESP) begin
                phase <= PH_IDLE;
            end else if (local_go) begin
                if (we) dat[idx] <= wdata;
                rdata <= we ? wdata : dat[idx];
                done  <= 1'b1;
                phase <= PH_RESP;
            end else if (active && grant) begin
                st[idx]  <= we ? LN_MOD : LN_SHR;
                tg[idx]  <= tag;
                dat[idx] <= we ? wdata : (hit ? dat[idx] : bus_rdata);
                rdata    <= we ? wdata : bus_rdata;
                done     <= 1'b1;
                phase    <= PH_RESP;
            end
            if (shit) begin
                if (cmd_takes_ownership(bus_cmd)) begin
                    st[sidx] <= LN_INV;
                end else if (bus_cmd == BC_READ && st[sidx] == LN_MOD) begin
                    st[sidx] <= LN_SHR;
                end
            end
        end
    end
endmodule

// File: rtl/snoop_cluster.sv
module snoop_cluster #(
    parameter int NCPU   = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4,
    localparam int OW    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCPU-1:0]          cpu_req,
    input  logic [NCPU-1:0]          cpu_we,
    input  logic [NCPU*ADDR_W-1:0]   cpu_addr,
    input  logic [NCPU*DATA_W-1:0]   cpu_wdata,
    output logic [NCPU-1:0]          cpu_done,
    output logic [NCPU*DATA_W-1:0]   cpu_rdata,
    output logic                     bus_valid,
    output logic [1:0]               bus_cmd,
    output logic [OW-1:0]            bus_owner,
    output logic [ADDR_W-1:0]        bus_addr
);
    import snoop_pkg::*;

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [NCPU-1:0]          breq, grant, c_wb_en, c_fl_en;
    bus_cmd_e                 c_cmd [NCPU];
    logic [ADDR_W-1:0]        c_wb_addr [NCPU];
    logic [DATA_W-1:0]        c_wb_data [NCPU];
    logic [DATA_W-1:0]        c_fl_data [NCPU];
    logic [NCPU*LINES-1:0]       val_flat, mod_flat;
    logic [NCPU*LINES*TAG_W-1:0] tag_flat;

    bus_cmd_e          cmd_q;
    logic [DATA_W-1:0] mem_rd, bus_rdata, fl_data;
    logic              fl_any;

    snoop_arb #(.N(NCPU)) u_arb (
        .clk(clk), .rst(rst), .req(breq), .grant(grant), .owner(bus_owner)
    );

    assign bus_valid = |grant;
    assign cmd_q     = bus_valid ? c_cmd[bus_owner] : BC_NONE;
    assign bus_cmd   = cmd_q;
    assign bus_addr  = cpu_addr[bus_owner*ADDR_W +: ADDR_W];

    always_comb begin
        fl_any  = 1'b0;
        fl_data = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (c_fl_en[i]) begin
                fl_any  = 1'b1;
                fl_data = c_fl_data[i];
            end
        end
    end

    assign bus_rdata = fl_any ? fl_data : mem_rd;

    snoop_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst),
        .rd_addr(bus_addr), .rd_data(mem_rd),
        .wb_en(bus_valid && c_wb_en[bus_owner]),
        .wb_addr(c_wb_addr[bus_owner]), .wb_data(c_wb_data[bus_owner]),
        .fl_en(fl_any), .fl_addr(bus_addr), .fl_data(fl_data)
    );

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_cpu
            snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
                .clk(clk), .rst(rst),
                .req(cpu_req[i]), .we(cpu_we[i]),
                .addr(cpu_addr[i*ADDR_W +: ADDR_W]),
                .wdata(cpu_wdata[i*DATA_W +: DATA_W]),
                .done(cpu_done[i]),
                .rdata(cpu_rdata[i*DATA_W +: DATA_W]),
                .bus_req(breq[i]), .grant(grant[i]),
                .bus_valid(bus_valid), .bus_cmd(cmd_q),
                .bus_addr(bus_addr), .bus_rdata(bus_rdata),
                .my_cmd(c_cmd[i]),
                .wb_en(c_wb_en[i]), .wb_addr(c_wb_addr[i]), .wb_data(c_wb_data[i]),
                .flush_en(c_fl_en[i]), .flush_data(c_fl_data[i]),
                .val_o(val_flat[i*LINES +: LINES]),
                .mod_o(mod_flat[i*LINES +: LINES]),
                .tag_o(tag_flat[i*LINES*TAG_W +: LINES*TAG_W])
            );
        end
    endgenerate
endmodule

// File: rtl/snoop_chk.sv
module snoop_chk #(
    parameter int NCPU  = 2,
    parameter int LINES = 4,
    parameter int TAG_W = 6
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NCPU-1:0]             grant,
    input logic                        bus_valid,
    input logic [1:0]                  bus_cmd,
    input logic [NCPU-1:0]             cpu_done,
    input logic [NCPU*LINES-1:0]       val_flat,
    input logic [NCPU*LINES-1:0]       mod_flat,
    input logic [NCPU*LINES*TAG_W-1:0] tag_flat
);
    a_r10_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r3_cmd_legal: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_cmd != 2'd0));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (cpu_done & $past(cpu_done)) == '0);

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_i
            for (genvar j = 0; j < NCPU; j++) begin : g_j
                if (i != j) begin : g_pair
                    for (genvar l = 0; l < LINES; l++) begin : g_l
                        a_r4_single_writer: assert property (@(posedge clk) disable iff (rst)
                            !(mod_flat[i*LINES+l] && val_flat[j*LINES+l] &&
                              tag_flat[(i*LINES+l)*TAG_W +: TAG_W] ==
                              tag_flat[(j*LINES+l)*TAG_W +: TAG_W]));
                    end
                end
            end
        end
    endgenerate
endmodule

bind snoop_cluster snoop_chk #(.NCPU(NCPU), .LINES(LINES), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst(rst), .grant(grant), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .cpu_done(cpu_done), .val_flat(val_flat), .mod_flat(mod_flat), .tag_flat(tag_flat)
);

// File: tb/tb_snoop_cluster.sv
module tb_snoop_cluster;
    localparam int NCPU = 2;
    localparam int AW = 8;
    localparam int DW = 8;

    typedef struct packed {
        logic       cpu;
        logic       we;
        logic [7:0] addr;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [1:0] cmd;
    } vec_t;

    // cmd: 0 none, 1 READ, 2 READ-EXCLUSIVE, 3 UPGRADE
    localparam vec_t VEC [13] = '{
        '{1'b0, 1'b0, 8'h10, 8'h00, 1'b1, 8'hB5, 2'd1},  // R1 R3 cold miss
        '{1'b0, 1'b0, 8'h10, 8'h00, 1'b1, 8'hB5, 2'd0},  // R2 hit
        '{1'b1, 1'b0, 8'h10, 8'h00, 1'b1, 8'hB5, 2'd1},  // R3 second sharer
        '{1'b0, 1'b1, 8'h10, 8'h66, 1'b0, 8'h00, 2'd3},  // R4 upgrade
        '{1'b1, 1'b0, 8'h10, 8'h00, 1'b1, 8'h66, 2'd1},  // R7 R8 flush
        '{1'b0, 1'b1, 8'h10, 8'h77, 1'b0, 8'h00, 2'd3},  // R7 downgraded
        '{1'b0, 1'b1, 8'h10, 8'h78, 1'b0, 8'h00, 2'd0},  // R6 modified hit
        '{1'b1, 1'b1, 8'h21, 8'h11, 1'b0, 8'h00, 2'd2},  // R5 store miss
        '{1'b1, 1'b0, 8'h21, 8'h00, 1'b1, 8'h11, 2'd0},  // R2 hit on modified
        '{1'b1, 1'b1, 8'h25, 8'h22, 1'b0, 8'h00, 2'd2},  // R9 evicts 0x21
        '{1'b0, 1'b0, 8'h21, 8'h00, 1'b1, 8'h11, 2'd1},  // R9 from memory
        '{1'b1, 1'b0, 8'h10, 8'h00, 1'b1, 8'h78, 2'd1},  // R8 invalidated copy
        '{1'b0, 1'b0, 8'h25, 8'h00, 1'b1, 8'h22, 2'd1}   // R7 flush of 0x25
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCPU-1:0]    cpu_req = '0, cpu_we = '0;
    logic [NCPU*AW-1:0] cpu_addr = '0;
    logic [NCPU*DW-1:0] cpu_wdata = '0;
    logic [NCPU-1:0]    cpu_done;
    logic [NCPU*DW-1:0] cpu_rdata;
    logic               bus_valid;
    logic [1:0]         bus_cmd;
    logic [0:0]         bus_owner;
    logic [AW-1:0]      bus_addr;

    int checks = 0, failures = 0;
    int txn_cnt = 0;
    logic [1:0] last_cmd = 2'd0;
    logic [0:0] owners [4];

    always #4 clk = ~clk;

    snoop_cluster #(.NCPU(NCPU), .ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_owner(bus_owner), .bus_addr(bus_addr)
    );

    always @(negedge clk) begin
        if (!rst && bus_valid) begin
            if (txn_cnt < 4) owners[txn_cnt] = bus_owner;
            txn_cnt  = txn_cnt + 1;
            last_cmd = bus_cmd;
        end
    end

    task automatic check(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(int c, logic w, logic [7:0] a, logic [7:0] d,
                         output logic [7:0] rd, output logic done_after);
        int n;
        @(posedge clk); #1;
        cpu_we[c] = w;
        cpu_addr[c*AW +: AW] = a;
        cpu_wdata[c*DW +: DW] = d;
        cpu_req[c] = 1'b1;
        txn_cnt = 0;
        last_cmd = 2'd0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (cpu_done[c] || n > 50) break;
        end
        rd = cpu_rdata[c*DW +: DW];
        @(posedge clk); #1;
        cpu_req[c] = 1'b0;
        @(negedge clk);
        done_after = cpu_done[c];
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic da;
        int got0, got1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", cpu_done == '0, cpu_done, 0);
        check("R1 bus idle after reset", bus_valid == 1'b0, bus_valid, 0);

        for (int v = 0; v < 13; v++) begin
            do_op(int'(VEC[v].cpu), VEC[v].we, VEC[v].addr, VEC[v].wd, rd, da);
            check($sformatf("R2-R9 vec%0d bus cmd", v), last_cmd == VEC[v].cmd,
                  last_cmd, VEC[v].cmd);
            check($sformatf("R2-R9 vec%0d txn count", v),
                  txn_cnt == ((VEC[v].cmd == 2'd0) ? 0 : 1),
                  txn_cnt, (VEC[v].cmd == 2'd0) ? 0 : 1);
            if (VEC[v].chk)
                check($sformatf("R7 R8 R9 vec%0d rdata", v), rd == VEC[v].exp, rd, VEC[v].exp);
            check($sformatf("R11 vec%0d done width", v), da == 1'b0, da, 0);
        end

        // R10: simultaneous misses from both processors
        @(posedge clk); #1;
        cpu_we = '0;
        cpu_addr = {8'h43, 8'h32};
        cpu_req = 2'b11;
        txn_cnt = 0;
        got0 = 0;
        got1 = 0;
        for (int k = 0; k < 12; k++) begin
            logic [1:0] drop;
            @(negedge clk);
            drop = cpu_done;
            if (cpu_done[0]) begin
                got0++;
                check("R10 cpu0 rdata", cpu_rdata[7:0] == 8'h97, cpu_rdata[7:0], 8'h97);
            end
            if (cpu_done[1]) begin
                got1++;
                check("R10 cpu1 rdata", cpu_rdata[15:8] == 8'hE6, cpu_rdata[15:8], 8'hE6);
            end
            @(posedge clk); #1;
            cpu_req = cpu_req & ~drop;
        end
        check("R10 two transactions", txn_cnt == 2, txn_cnt, 2);
        check("R10 distinct owners", owners[0] != owners[1], owners[1], 32'(!owners[0]));
        check("R11 one pulse cpu0", got0 == 1, got0, 1);
        check("R11 one pulse cpu1", got1 == 1, got1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule